// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Slave

This block is the command engine of a small serial EEPROM with 256 words of 8 bits, kept in an on-chip register array. It runs on a fast system clock, oversamples the external chip-select, serial clock and data-in pins through a synchroniser, and acts once for each rising edge of the serial clock that it detects while chip-select is high. A master frames each instruction as a start bit, a 2-bit opcode and a 9-bit address field (one don't-care bit, then the word address MSB first), followed by 8 data bits MSB first when the command carries data.

The serial pins are the only data path. There is no valid/ready handshake and no back-pressure: the master sets the pace with the serial clock. The slave must see each pin level for at least SYNC_STAGES+1 system clocks. Read data, and the ready/busy flag after a programming command, leave on a serial output that has its own output-enable, so a pad can place it in high impedance. Programming time is modelled with a counter of system clocks. Its length depends on the operation.

Top module: `mw_eeprom_slave`

## Requirements
- R1: After reset the output-enable is low, the write-enable latch is clear, and every word of the array reads as 8'hFF.
- R2: While chip-select is high, rising serial-clock edges with data-in low are ignored until the first edge that samples data-in high, which is taken as the start bit.
- R3: While the write-enable latch is clear, ERASE, WRITE, ERAL and WRAL do not change the array and start no busy period, so no status is driven after chip-select is reasserted.
- R4: Opcode 10 is READ. Twelve edges in total (start, opcode, don't-care, 8 address bits) are needed. After the edge of the last address bit the output is enabled and drives a single 0. The next 8 edges each present one data bit, MSB first.
- R5: If clocking continues after the last bit of a read word, the next word follows at once, without a dummy bit, and the address wraps from 255 to 0.
- R6: Opcode 11 is ERASE. It sets the addressed word to 8'hFF.
- R7: Opcode 00 with sub-code 10 in the first two address-field bits is ERAL. It sets every word to 8'hFF.
- R8: Opcode 00 with sub-code 01 is WRAL. It takes 8 data bits and writes that value into every word.
- R9: Opcode 00 with sub-code 11 (EWEN) sets the write-enable latch. Sub-code 00 (EWDS) clears it.
- R10: A programming cycle begins at the edge of its last bit and lasts T_WORD, T_ALL_ERASE or T_ALL_WRITE system clocks. While it runs, if chip-select is taken low and then high again, the output is enabled and drives 0. Once the cycle ends, the output drives 1.
- R11: Taking chip-select low aborts any partial command, and the output is disabled within SYNC_STAGES+1 system clocks. A programming cycle that has already begun still completes.
- R12: A start bit that arrives while a programming cycle is busy is ignored, together with the rest of that command.
- R13: After the last required bit of a command, further serial-clock edges are ignored until chip-select goes low.
- R14: Opcode 01 is WRITE. It takes 8 data bits MSB first and stores them at the addressed word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mw_cs | input | 1 | Chip-select from the serial master, asynchronous |
| mw_sclk | input | 1 | Serial clock from the master, asynchronous |
| mw_di | input | 1 | Serial data in |
| mw_do | output | 1 | Serial data out: read bits or the ready/busy flag |
| mw_do_oe | output | 1 | Output-enable for mw_do; low means high impedance |

## Verification
Most internal faults show on the next read transaction. If the bit counter is off by one, the dummy zero lands on the wrong edge and every word reads back shifted. A wrong address decode or a wrong wrap puts a word in the wrong slot, and a full-array sweep finds it. A fault in the write-enable latch or the busy guard shows on the following readback or status poll. A timer of the wrong length moves the rising edge of the ready flag outside a window of a few system clocks.

// File: rtl/mw_pkg.sv
package mw_pkg;
  typedef enum logic [2:0] {ST_IDLE, ST_CMD, ST_DATA, ST_READ, ST_DONE} mw_state_e;
  typedef enum logic [1:0] {DUR_WORD, DUR_ALL_ERASE, DUR_ALL_WRITE} mw_dur_e;

  localparam logic [1:0] OPC_EXT   = 2'b00;
  localparam logic [1:0] OPC_WRITE = 2'b01;
  localparam logic [1:0] OPC_READ  = 2'b10;
  localparam logic [1:0] OPC_ERASE = 2'b11;

  localparam logic [1:0] SUB_DIS   = 2'b00;
  localparam logic [1:0] SUB_WRALL = 2'b01;
  localparam logic [1:0] SUB_ERALL = 2'b10;
  localparam logic [1:0] SUB_EN    = 2'b11;
endpackage

// File: rtl/mw_in_sync.sv
module mw_in_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_async,
  output logic [WIDTH-1:0] d_sync
);
  logic [WIDTH-1:0] chain [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[0] <= '0;
        else        chain[0] <= d_async;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[g] <= '0;
        else        chain[g] <= chain[g-1];
      end
    end
  end

  assign d_sync = chain[STAGES-1];
endmodule

// File: rtl/mw_prog_timer.sv
module mw_prog_timer
  import mw_pkg::*;
#(
  parameter int T_WORD      = 200,
  parameter int T_ALL_ERASE = 600,
  parameter int T_ALL_WRITE = 1500
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    start,
  input  mw_dur_e sel,
  output logic    busy,
  output logic    done
);
  localparam int TMAX12 = (T_WORD > T_ALL_ERASE) ? T_WORD : T_ALL_ERASE;
  localparam int TMAX   = (TMAX12 > T_ALL_WRITE) ? TMAX12 : T_ALL_WRITE;
  localparam int CNT_W  = $clog2(TMAX + 1);

  localparam logic [CNT_W-1:0] LD_WORD  = CNT_W'(T_WORD - 1);
  localparam logic [CNT_W-1:0] LD_ERALL = CNT_W'(T_ALL_ERASE - 1);
  localparam logic [CNT_W-1:0] LD_WRALL = CNT_W'(T_ALL_WRITE - 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] load;
  logic             busy_q;

  always_comb begin
    unique case (sel)
      DUR_ALL_ERASE: load = LD_ERALL;
      DUR_ALL_WRITE: load = LD_WRALL;
      default:       load = LD_WORD;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (start && !busy_q) begin
      busy_q <= 1'b1;
      cnt_q  <= load;
    end else if (busy_q) begin
      if (cnt_q == '0) busy_q <= 1'b0;
      else             cnt_q  <= cnt_q - 1'b1;
    end
  end

  assign busy = busy_q;
  assign done = busy_q && (cnt_q == '0);
endmodule

// File: rtl/mw_word_array.sv
module mw_word_array #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_one,
  input  logic              we_all,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] words [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) words[i] <= '1;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (we_all || (we_one && waddr == ADDR_W'(i))) words[i] <= wdata;
      end
    end
  end

  assign rdata = words[raddr];
endmodule

// File: rtl/mw_eeprom_slave.sv
module mw_eeprom_slave
  import mw_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 8,
  parameter int T_WORD      = 200,
  parameter int T_ALL_ERASE = 600,
  parameter int T_ALL_WRITE = 1500,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mw_cs,
  input  logic mw_sclk,
  input  logic mw_di,
  output logic mw_do,
  output logic mw_do_oe
);
  localparam int AF_W     = ADDR_W + 1;
  localparam int CMD_BITS = 2 + AF_W;
  localparam int BC_W     = $clog2(CMD_BITS + DATA_W + 1);
  localparam logic [BC_W-1:0] CMD_LAST = BC_W'(CMD_BITS - 1);
  localparam logic [BC_W-1:0] DAT_LAST = BC_W'(DATA_W - 1);

  // pin synchroniser and edge detect
  logic [2:0] pins_s;
  logic       cs_s, sclk_s, di_s, sclk_prev, rise;

  mw_in_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .d_async({mw_cs, mw_sclk, mw_di}),
    .d_sync (pins_s)
  );

  assign cs_s   = pins_s[2];
  assign sclk_s = pins_s[1];
  assign di_s   = pins_s[0];
  assign rise   = cs_s && sclk_s && !sclk_prev;

  // command state
  mw_state_e         st_q;
  logic [BC_W-1:0]   bcnt_q;
  logic [CMD_BITS-2:0] cmd_q;
  logic [DATA_W-2:0] dat_q;
  logic [DATA_W-1:0] rd_sr_q;
  logic [ADDR_W-1:0] rd_addr_q;
  logic              do_q;
  logic              wen_q;
  logic              stat_q;
  logic [ADDR_W-1:0] pg_addr_q;
  logic [DATA_W-1:0] pg_data_q;
  logic              pg_all_q;

  logic [CMD_BITS-1:0] cmd_nxt;
  logic [DATA_W-1:0]   dat_nxt;
  logic [1:0]          opc, sub;
  logic [ADDR_W-1:0]   cmd_addr, rd_port;
  logic [DATA_W-1:0]   rdata;
  logic                cmd_last, data_last;
  logic                erase_go, eral_go, dat_go, pg_start;
  mw_dur_e             pg_sel;
  logic                busy, pg_done;

  always_comb begin
    cmd_nxt   = {cmd_q, di_s};
    dat_nxt   = {dat_q, di_s};
    opc       = cmd_nxt[CMD_BITS-1 -: 2];
    sub       = cmd_nxt[CMD_BITS-3 -: 2];
    cmd_addr  = cmd_nxt[ADDR_W-1:0];
    cmd_last  = (st_q == ST_CMD)  && rise && (bcnt_q == CMD_LAST);
    data_last = (st_q == ST_DATA) && rise && (bcnt_q == DAT_LAST);
    erase_go  = cmd_last && (opc == OPC_ERASE) && wen_q;
    eral_go   = cmd_last && (opc == OPC_EXT) && (sub == SUB_ERALL) && wen_q;
    dat_go    = data_last && wen_q;
    pg_start  = erase_go || eral_go || dat_go;
    if (eral_go)                pg_sel = DUR_ALL_ERASE;
    else if (dat_go && pg_all_q) pg_sel = DUR_ALL_WRITE;
    else                         pg_sel = DUR_WORD;
    rd_port   = (st_q == ST_READ) ? rd_addr_q + 1'b1 : cmd_addr;
  end

  mw_prog_timer #(
    .T_WORD     (T_WORD),
    .T_ALL_ERASE(T_ALL_ERASE),
    .T_ALL_WRITE(T_ALL_WRITE)
  ) u_timer (
    .clk  (clk),
    .rst_n(rst_n),
    .start(pg_start),
    .sel  (pg_sel),
    .busy (busy),
    .done (pg_done)
  );

  mw_word_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
    .clk   (clk),
    .rst_n (rst_n),
    .we_one(pg_done && !pg_all_q),
    .we_all(pg_done && pg_all_q),
    .waddr (pg_addr_q),
    .wdata (pg_data_q),
    .raddr (rd_port),
    .rdata (rdata)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_prev <= 1'b0;
      st_q      <= ST_IDLE;
      bcnt_q    <= '0;
      cmd_q     <= '0;
      dat_q     <= '0;
      rd_sr_q   <= '0;
      rd_addr_q <= '0;
      do_q      <= 1'b0;
      wen_q     <= 1'b0;
      stat_q    <= 1'b0;
      pg_addr_q <= '0;
      pg_data_q <= '0;
      pg_all_q  <= 1'b0;
    end else begin
      sclk_prev <= sclk_s;
      if (pg_start) stat_q <= 1'b1;
      if (!cs_s) begin
        st_q <= ST_IDLE;
      end else if (rise) begin
        unique case (st_q)
          ST_IDLE: begin
            if (di_s && !busy) begin
              st_q   <= ST_CMD;
              bcnt_q <= '0;
              stat_q <= 1'b0;
            end
          end
          ST_CMD: begin
            cmd_q  <= cmd_nxt[CMD_BITS-2:0];
            bcnt_q <= bcnt_q + 1'b1;
            if (bcnt_q == CMD_LAST) begin
              bcnt_q    <= '0;
              st_q      <= ST_DONE;
              pg_addr_q <= cmd_addr;
              unique case (opc)
                OPC_READ: begin
                  st_q      <= ST_READ;
                  do_q      <= 1'b0;
                  rd_sr_q   <= rdata;
                  rd_addr_q <= cmd_addr;
                end
                OPC_WRITE: begin
                  st_q     <= ST_DATA;
                  pg_all_q <= 1'b0;
                end
                OPC_ERASE: begin
                  pg_all_q  <= 1'b0;
                  pg_data_q <= '1;
                end
                default: begin
                  unique case (sub)
                    SUB_EN:  wen_q <= 1'b1;
                    SUB_DIS: wen_q <= 1'b0;
                    SUB_ERALL: begin
                      pg_all_q  <= 1'b1;
                      pg_data_q <= '1;
                    end
                    default: begin
                      st_q     <= ST_DATA;
                      pg_all_q <= 1'b1;
                    end
                  endcase
                end
              endcase
            end
          end
          ST_DATA: begin
            dat_q  <= dat_nxt[DATA_W-2:0];
            bcnt_q <= bcnt_q + 1'b1;
            if (bcnt_q == DAT_LAST) begin
              bcnt_q    <= '0;
              st_q      <= ST_DONE;
              pg_data_q <= dat_nxt;
            end
          end
          ST_READ: begin
            do_q <= rd_sr_q[DATA_W-1];
            if (bcnt_q == DAT_LAST) begin
              rd_sr_q   <= rdata;
              rd_addr_q <= rd_addr_q + 1'b1;
              bcnt_q    <= '0;
            end else begin
              rd_sr_q <= {rd_sr_q[DATA_W-2:0], 1'b0};
              bcnt_q  <= bcnt_q + 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign mw_do_oe = cs_s && ((st_q == ST_READ) || ((st_q == ST_IDLE) && stat_q));
  assign mw_do    = (st_q == ST_READ) ? do_q : !busy;
endmodule

// File: rtl/mw_eeprom_chk.sv
module mw_eeprom_chk
  import mw_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input logic      clk,
  input logic      rst_n,
  input logic      mw_cs,
  input logic      mw_do,
  input logic      mw_do_oe,
  input logic      busy,
  input logic      wen,
  input mw_state_e st
);
  logic [3:0] lo_cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                lo_cnt_q <= '0;
    else if (mw_cs)            lo_cnt_q <= '0;
    else if (lo_cnt_q != 4'hF) lo_cnt_q <= lo_cnt_q + 1'b1;
  end

  // R11: chip-select held low long enough disables the output
  a_r11_cs_low_hiz: assert property (@(posedge clk) disable iff (!rst_n)
    (!mw_cs && (int'(lo_cnt_q) >= SYNC_STAGES)) |-> !mw_do_oe);

  // R3: a busy period only starts with the write-enable latch set
  a_r3_prog_needs_wen: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> wen);

  // R12: no command is accepted while programming is busy
  a_r12_no_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE && busy) |=> (st != ST_CMD));

  // R4: the first bit after entering read is the dummy zero
  a_r4_dummy_zero: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st == ST_READ) |-> !mw_do);
endmodule

bind mw_eeprom_slave mw_eeprom_chk #(.SYNC_STAGES(SYNC_STAGES)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .mw_cs   (mw_cs),
  .mw_do   (mw_do),
  .mw_do_oe(mw_do_oe),
  .busy    (busy),
  .wen     (wen_q),
  .st      (st_q)
);

// File: tb/tb_mw_eeprom_slave.sv
module tb_mw_eeprom_slave;
  localparam int TW = 40;
  localparam int TE = 160;
  localparam int TA = 400;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mw_cs = 1'b0, mw_sclk = 1'b0, mw_di = 1'b0;
  logic mw_do, mw_do_oe;

  always #4 clk = ~clk;

  mw_eeprom_slave #(
    .T_WORD(TW), .T_ALL_ERASE(TE), .T_ALL_WRITE(TA)
  ) dut (
    .clk(clk), .rst_n(rst_n), .mw_cs(mw_cs), .mw_sclk(mw_sclk),
    .mw_di(mw_di), .mw_do(mw_do), .mw_do_oe(mw_do_oe)
  );

  int total = 0, fails = 0, cyc = 0, t_rise = 0;
  bit finished = 1'b0;
  logic last_do, last_oe;
  logic [7:0] model [256];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bit(input logic b);
    mw_di = b;
    tick(1);
    mw_sclk = 1'b1;
    t_rise = cyc;
    tick(4);
    last_do = mw_do;
    last_oe = mw_do_oe;
    mw_sclk = 1'b0;
    tick(3);
  endtask

  task automatic cs_gap();
    mw_sclk = 1'b0;
    mw_di = 1'b0;
    mw_cs = 1'b0;
    tick(4);
    mw_cs = 1'b1;
    tick(4);
  endtask

  task automatic send_cmd(input logic [1:0] op, input logic [8:0] af);
    send_bit(1'b1);
    for (int i = 1; i >= 0; i--) send_bit(op[i]);
    for (int i = 8; i >= 0; i--) send_bit(af[i]);
  endtask

  task automatic send_byte(input logic [7:0] d);
    for (int i = 7; i >= 0; i--) send_bit(d[i]);
  endtask

  task automatic wait_ready(input int t0, input int dur, input string req);
    int el;
    chk(mw_do_oe && !mw_do, req, {mw_do_oe, mw_do}, 2'b10);
    for (int i = 0; i < dur + 60; i++) begin
      if (mw_do_oe && mw_do) break;
      tick(1);
    end
    el = cyc - t0;
    chk(el >= dur + 2 && el <= dur + 5, req, el, dur + 3);
  endtask

  task automatic read_words(input int a, input int n, input string req, input bit gap);
    logic [7:0] v;
    if (gap) cs_gap();
    send_cmd(2'b10, {1'b0, 8'(a)});
    chk(last_oe && !last_do, "R4 dummy", {last_oe, last_do}, 2'b10);
    for (int i = 0; i < n; i++) begin
      v = '0;
      for (int b = 0; b < 8; b++) begin
        send_bit(1'b0);
        v = {v[6:0], last_do};
      end
      chk(v == model[(a + i) % 256], req, v, model[(a + i) % 256]);
    end
  endtask

  task automatic prog_write(input int a, input logic [7:0] d);
    int t0;
    cs_gap();
    send_cmd(2'b01, {1'b0, 8'(a)});
    send_byte(d);
    t0 = t_rise;
    cs_gap();
    wait_ready(t0, TW, "R10 R14 write status");
    model[a] = d;
  endtask

  initial begin
    int t0;
    for (int i = 0; i < 256; i++) model[i] = 8'hFF;
    tick(3);
    rst_n = 1'b1;
    tick(2);
    chk(!mw_do_oe, "R1 oe after reset", mw_do_oe, 0);

    // R2: edges with DI low are ignored, then a start is accepted
    mw_cs = 1'b1;
    tick(4);
    begin
      bit any_oe = 1'b0;
      for (int i = 0; i < 6; i++) begin
        send_bit(1'b0);
        if (last_oe) any_oe = 1'b1;
      end
      chk(!any_oe, "R2 idle clocks", any_oe, 0);
    end
    read_words(0, 2, "R1 R2 reset content", 1'b0);

    // R3: write without enable
    cs_gap();
    send_cmd(2'b01, 9'h005);
    send_byte(8'h3C);
    cs_gap();
    chk(!mw_do_oe, "R3 no status", mw_do_oe, 0);
    read_words(5, 1, "R3 write blocked", 1'b1);

    // R9 enable, R14 write every word
    cs_gap();
    send_cmd(2'b00, 9'b11_0000000);
    for (int a = 0; a < 256; a++) prog_write(a, 8'((a * 37 + 11) & 255));

    // R4 R5 full sequential read with wrap
    read_words(0, 258, "R4 R5 sequential", 1'b1);
    read_words(250, 10, "R5 wrap", 1'b1);

    // R6 erase one word
    cs_gap();
    send_cmd(2'b11, 9'h007);
    t0 = t_rise;
    cs_gap();
    wait_ready(t0, TW, "R6 R10 erase status");
    model[7] = 8'hFF;
    read_words(6, 3, "R6 erase", 1'b1);

    // R11 abort mid-command, then a clean read
    cs_gap();
    send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
    send_bit(1'b0); send_bit(1'b0); send_bit(1'b0);
    read_words(9, 1, "R11 abort", 1'b1);

    // R11 chip-select low during read disables output
    cs_gap();
    send_cmd(2'b10, 9'h009);
    send_bit(1'b0); send_bit(1'b0); send_bit(1'b0);
    mw_cs = 1'b0;
    tick(4);
    chk(!mw_do_oe, "R11 hiz on cs low", mw_do_oe, 0);

    // R11 programming completes with chip-select low
    cs_gap();
    send_cmd(2'b01, 9'h00A);
    send_byte(8'hA5);
    mw_cs = 1'b0;
    tick(TW + 10);
    model[10] = 8'hA5;
    read_words(10, 1, "R11 prog with cs low", 1'b1);

    // R7 erase-all; R12 an EWDS sent while busy is ignored
    cs_gap();
    send_cmd(2'b00, 9'b10_0000000);
    t0 = t_rise;
    cs_gap();
    send_cmd(2'b00, 9'b00_0000000);
    cs_gap();
    wait_ready(t0, TE, "R7 R10 erase-all status");
    for (int i = 0; i < 256; i++) model[i] = 8'hFF;
    read_words(0, 256, "R7 erase-all", 1'b1);
    prog_write(3, 8'h77);
    read_words(3, 1, "R12 ewds ignored when busy", 1'b1);

    // R8 write-all
    cs_gap();
    send_cmd(2'b00, 9'b01_0000000);
    send_byte(8'hC3);
    t0 = t_rise;
    cs_gap();
    wait_ready(t0, TA, "R8 R10 write-all status");
    for (int i = 0; i < 256; i++) model[i] = 8'hC3;
    read_words(0, 256, "R8 write-all", 1'b1);

    // R13 an enable pattern clocked after EWDS under the same select is ignored
    cs_gap();
    send_cmd(2'b00, 9'b00_0000000);
    send_cmd(2'b00, 9'b11_0000000);
    cs_gap();
    send_cmd(2'b01, 9'h004);
    send_byte(8'h22);
    cs_gap();
    chk(!mw_do_oe, "R13 no status", mw_do_oe, 0);
    read_words(4, 1, "R13 trailing clocks ignored", 1'b1);

    // R9 enable then disable
    cs_gap();
    send_cmd(2'b00, 9'b11_0000000);
    prog_write(4, 8'h22);
    cs_gap();
    send_cmd(2'b00, 9'b00_0000000);
    cs_gap();
    send_cmd(2'b01, 9'h005);
    send_byte(8'h33);
    cs_gap();
    chk(!mw_do_oe, "R9 disabled no status", mw_do_oe, 0);
    read_words(4, 2, "R9 enable/disable", 1'b1);

    mw_cs = 1'b0;
    tick(4);
    finished = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (195000) @(posedge clk);
    if (!finished) begin
      total++;
      fails++;
      $display("FAIL watchdog expired before the sequence finished");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule